// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

The block is an eight-pin general-purpose I/O port on a simple memory-mapped bus. Two registers control it. A write-only direction register sets each pin as an input or an output. A read/write data register holds the values that output pins drive. A read of the data register returns a per-pin mix: output pins return their latch bit, and input pins return the pin level after a two-flop synchronizer.

Each pin can also be handed to an on-chip timer. Its alternate-enable input forces the pin to drive the timer's value. The port has two standby inputs:

- Hardware standby releases every pin and clears the direction register.
- Software standby leaves the direction register alone, so output pins keep driving. Bus writes are ignored while either standby is active.

The pad side has three vectors: output value, output enable and input level.

Top module: `pio_port8`

## Requirements
- R1: After reset the direction register and the data register are 8'h00. `pad_oe` and `pad_out` are 0, and a data-register read returns the synchronized pin levels.
- R2: Writing the direction register (address 16'hFF8C) with bit n set to 1 makes pin n an output. Bit n cleared makes it an input. `pad_oe` shows the new value from the clock edge that takes the write.
- R3: A read of address 16'hFF8C always returns 8'hFF, whatever is stored in the direction register.
- R4: A read of the data register (address 16'hFF8E) returns, for each pin, the data register bit if the pin is an output, and the synchronized pin level if it is an input.
- R5: A change on `pad_in` shows in a data-register read after two rising clock edges, and not after only one.
- R6: A data-register write updates the latch and `pad_out` whatever the direction setting. A value preloaded while the pin is an input is driven and read back once the pin becomes an output.
- R7: While `hw_stby` is 1:
  - `pad_oe` is 8'h00, including pins with the alternate enable set.
  - The direction register is cleared to 8'h00.
  - Bus writes are ignored.
  - The data register keeps its value.
- R8: While `sw_stby` is 1, bus writes are ignored. The direction register, `pad_oe` and `pad_out` keep their values.
- R9: Outside hardware standby, a pin with `alt_oe` bit set is forced to output. Its `pad_out` bit follows `alt_out`, regardless of the direction and data bits.
- R10: A read of any other address returns 8'h00. A write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: releases pins, clears direction |
| sw_stby | input | 1 | Software standby: keeps state, blocks writes |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| alt_oe | input | 8 | Per-pin timer output enable |
| alt_out | input | 8 | Per-pin timer output value |
| pad_in | input | 8 | Pin input levels (asynchronous) |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |

## Verification
Read data is combinational, so a read is sampled one time step after the address is applied, in the same low clock phase. A register write becomes visible at `pad_oe` and `pad_out` after the single rising edge that takes it, and the bench samples those at the following falling edge. A pin level needs two rising edges before it can be read. The bench therefore waits three edges after changing `pad_in` in its table walk, and in the R5 test it reads exactly one and two edges after the change. Standby and alternate-function effects on the pad enables are combinational, and the bench checks them in the same low phase in which they are applied.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DIR  = 2'd1,
        ACC_DAT  = 2'd2
    } pio_acc_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int              W        = 8,
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFF8C,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFF8E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      dat
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dat;
    } reg_state_t;

    reg_state_t st_d, st_q;
    pio_acc_e   acc;
    logic       wr_ok;

    always_comb begin
        if (!bus_sel)                  acc = ACC_NONE;
        else if (bus_addr == DIR_ADDR) acc = ACC_DIR;
        else if (bus_addr == DAT_ADDR) acc = ACC_DAT;
        else                           acc = ACC_NONE;
    end

    assign wr_ok = bus_we && !hw_stby && !sw_stby;

    always_comb begin
        st_d = st_q;
        if (wr_ok && acc == ACC_DIR) st_d.dir = bus_wdata;
        if (wr_ok && acc == ACC_DAT) st_d.dat = bus_wdata;
        if (hw_stby)                 st_d.dir = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (acc)
            ACC_DIR: bus_rdata = '1;
            ACC_DAT: bus_rdata = (st_q.dat & st_q.dir) | (pin_sync & ~st_q.dir);
            default: bus_rdata = '0;
        endcase
    end

    assign dir = st_q.dir;
    assign dat = st_q.dat;
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
    parameter int W = 8
) (
    input  logic         hw_stby,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dat,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        assign pad_out[g] = alt_oe[g] ? alt_out[g] : dat[g];
        assign pad_oe[g]  = !hw_stby && (dir[g] || alt_oe[g]);
    end
endmodule

// File: rtl/pio_port8.sv
module pio_port8 #(
    parameter int                W           = 8,
    parameter int                ADDR_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFF8C,
    parameter logic [ADDR_W-1:0] DAT_ADDR    = 16'hFF8E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      alt_oe,
    input  logic [W-1:0]      alt_out,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] dir;
    logic [W-1:0] dat;

    pio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    pio_regs #(.W(W), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_stby  (hw_stby),
        .sw_stby  (sw_stby),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pin_sync (pin_sync),
        .bus_rdata(bus_rdata),
        .dir      (dir),
        .dat      (dat)
    );

    pio_pad_mux #(.W(W)) u_mux (
        .hw_stby(hw_stby),
        .dir    (dir),
        .dat    (dat),
        .alt_oe (alt_oe),
        .alt_out(alt_out),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );
endmodule

// File: rtl/pio_port8_chk.sv
module pio_port8_chk #(
    parameter int                W        = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFF8C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      alt_oe,
    input logic [W-1:0]      alt_out,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe
);
    AST_HW_STBY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> pad_oe == '0); // R7

    AST_HW_STBY_DIR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hw_stby) |-> (pad_oe & ~alt_oe) == '0); // R7

    AST_ALT_FORCES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_stby |-> (pad_oe & alt_oe) == alt_oe); // R9

    AST_ALT_DRIVES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ alt_out) & alt_oe) == '0); // R9

    AST_SW_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && alt_oe == '0) |=>
        (!sw_stby || hw_stby || alt_oe != '0 || ($stable(pad_oe) && $stable(pad_out)))); // R8

    AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == DIR_ADDR) |-> bus_rdata == '1); // R3
endmodule

bind pio_port8 pio_port8_chk #(.W(W), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_stby  (hw_stby),
    .sw_stby  (sw_stby),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .alt_oe   (alt_oe),
    .alt_out  (alt_out),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/pio_port8_tb.sv
`timescale 1ns/1ps
module pio_port8_tb;
    localparam logic [15:0] A_DIR = 16'hFF8C;
    localparam logic [15:0] A_DAT = 16'hFF8E;
    localparam logic [15:0] A_BAD = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_stby = 1'b0, sw_stby = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  alt_oe = '0, alt_out = '0, pad_in = '0;
    logic [7:0]  pad_out, pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_port8 u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  pad;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, A_DAT, 8'hA5, 8'h00, 8'h00, 4'd6},  // R6 preload
        '{1'b0, A_DAT, 8'h00, 8'h3C, 8'h3C, 4'd4},  // R4 all inputs
        '{1'b1, A_DIR, 8'hF0, 8'h00, 8'h00, 4'd2},  // R2
        '{1'b0, A_DIR, 8'h00, 8'h00, 8'hFF, 4'd3},  // R3
        '{1'b0, A_DAT, 8'h00, 8'h0F, 8'hAF, 4'd4},  // R4 mixed
        '{1'b0, A_DAT, 8'h00, 8'hFF, 8'hAF, 4'd4},  // R4 outputs ignore pins
        '{1'b1, A_DAT, 8'h5A, 8'h00, 8'h00, 4'd6},
        '{1'b0, A_DAT, 8'h00, 8'h00, 8'h50, 4'd4},
        '{1'b0, A_BAD, 8'h00, 8'h00, 8'h00, 4'd10}, // R10 read
        '{1'b1, A_BAD, 8'hFF, 8'h00, 8'h00, 4'd10}, // R10 write
        '{1'b0, A_DAT, 8'h00, 8'h00, 8'h50, 4'd10}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        rst_n = 1'b1;
        pad_in = 8'h66;
        repeat (3) @(negedge clk);
        rd(A_DAT, r);
        chk("R1 data read", r, 8'h66);

        // table walk
        for (int i = 0; i < NV; i++) begin
            pad_in = VECS[i].pad;
            repeat (3) @(negedge clk);
            if (VECS[i].we) begin
                wr(VECS[i].addr, VECS[i].wdata);
            end else begin
                rd(VECS[i].addr, r);
                checks++;
                if (r !== VECS[i].exp) begin
                    failures++;
                    $display("FAIL R%0d row %0d actual=%02h expected=%02h",
                             VECS[i].req, i, r, VECS[i].exp);
                end
            end
        end

        // R2 direction reaches pad_oe after the write edge
        wr(A_DIR, 8'h0F);
        chk("R2 pad_oe", pad_oe, 8'h0F);

        // R5 two-edge synchronizer
        wr(A_DIR, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h81;
        @(negedge clk);
        #1 bus_sel = 1'b1; bus_addr = A_DAT; bus_we = 1'b0;
        #1 chk("R5 after one edge", bus_rdata, 8'h00);
        @(negedge clk);
        #1 chk("R5 after two edges", bus_rdata, 8'h81);
        bus_sel = 1'b0;

        // R6 preload while input, then enable
        wr(A_DAT, 8'hC3);
        chk("R6 pad_out preload", pad_out, 8'hC3);
        chk("R6 pad_oe still off", pad_oe, 8'h00);
        wr(A_DIR, 8'hFF);
        rd(A_DAT, r);
        chk("R6 read after enable", r, 8'hC3);

        // R9 alternate function
        wr(A_DIR, 8'h00);
        @(negedge clk);
        alt_oe = 8'h80; alt_out = 8'h80;
        #1 chk("R9 oe forced", pad_oe, 8'h80);
        chk("R9 out high", pad_out, 8'hC3);
        alt_out = 8'h00;
        #1 chk("R9 out low", pad_out, 8'h43);
        alt_oe = 8'h00;

        // R8 software standby keeps state and blocks writes
        wr(A_DIR, 8'hFF);
        wr(A_DAT, 8'h3C);
        sw_stby = 1'b1;
        wr(A_DAT, 8'h00);
        wr(A_DIR, 8'h00);
        chk("R8 pad_out held", pad_out, 8'h3C);
        chk("R8 pad_oe held", pad_oe, 8'hFF);
        @(negedge clk);
        sw_stby = 1'b0;

        // R7 hardware standby
        @(negedge clk);
        hw_stby = 1'b1; alt_oe = 8'h01;
        #1 chk("R7 oe released", pad_oe, 8'h00);
        wr(A_DAT, 8'h99);
        @(negedge clk);
        hw_stby = 1'b0; alt_oe = 8'h00;
        #1 chk("R7 dir cleared", pad_oe, 8'h00);
        wr(A_DIR, 8'hFF);
        rd(A_DAT, r);
        chk("R7 data kept", r, 8'h3C);

        finish_run();
    end
endmodule